// File: doc/BRIEF.md
# Minifloat Adder/Subtractor with Renormalization

This block adds or subtracts two values in a tiny floating-point format. Each value has a sign bit at the top, a 4-bit biased exponent (bias 7) and a 3-bit fraction. The exponent and fraction widths are parameters. The block accepts two operands and a subtract select, and returns the rounded sum with three flags: overflow, inexact and invalid.

The datapath works in four steps:
- It orders the operands by magnitude.
- It shifts the smaller significand right, folding every bit lost off the end into a sticky bit.
- It adds or subtracts the signed significands.
- It renormalizes the result. A carry-out gives one step right. Cancellation gives a leading-zero-count shift left, which never goes below the denormal exponent.

Rounding is to nearest with ties to even, using guard, round and sticky bits. Denormals, signed zeros, infinities and NaN are all handled.

Operands enter over a valid/ready stream and results leave over a second one.
- An input is taken on a clock edge where `s_valid` and `s_ready` are both high.
- Its result is presented, registered, from the next cycle.
- `s_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `m_valid` is high and `m_ready` is low, the result and flags stay frozen and no new operand is taken.

Top module: `mf_adder`

## Requirements
- R1: A finite operand pair gives the finite sum (or difference when `s_sub` is 1, which negates `s_b`), rounded to nearest. `m_inx` is 1 exactly when the rounded value differs from the exact sum.
- R2: Significand bits shifted out while aligning the smaller operand still affect rounding through a sticky bit. For example, 1.0 (0x38) plus the smallest denormal (0x01) returns 0x38 with `m_inx` = 1.
- R3: An exact tie between two representable values rounds to the one whose fraction LSB is 0. For example, 0x38 + 0x18 gives 0x38 and 0x39 + 0x18 gives 0x3A.
- R4: An exponent field of 0 is a denormal. Its scale is the same as exponent field 1 and it has no hidden 1. Left renormalization stops at that scale, so tiny results come out with exponent field 0. For example, 0x08 − 0x01 gives 0x07.
- R5: A rounded magnitude that reaches 2^8 returns infinity of the result sign (exponent all ones, fraction 0, for example 0x78), with `m_ovf` = 1 and `m_inx` = 1.
- R6: If either operand is NaN (exponent all ones, fraction non-zero), the result is the canonical quiet NaN 0x7C (sign 0, exponent 1111, fraction 100) and all flags are 0.
- R7: Infinities of opposite effective sign return 0x7C with `m_inv` = 1 and the other flags 0.
- R8: An exact zero sum is +0 (0x00), unless both addends are zeros with a negative effective sign, which gives −0 (0x80).
- R9: Infinity combined with a finite value, or with an infinity of the same effective sign, returns that infinity with all flags 0.
- R10: `s_ready` is 1 when `m_valid` is 0 or `m_ready` is 1. An accepted input gives `m_valid` = 1 on the next cycle. While `m_valid` is 1 and `m_ready` is 0, `m_valid`, the result and the flags hold their values.
- R11: After reset, `m_valid` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Operand pair valid |
| s_ready | output | 1 | Block can take an operand pair |
| s_a | input | 8 | First operand |
| s_b | input | 8 | Second operand |
| s_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream takes the result |
| m_result | output | 8 | Rounded result |
| m_ovf | output | 1 | Overflow to infinity |
| m_inx | output | 1 | Result not exact |
| m_inv | output | 1 | Invalid operation (opposite infinities) |

## Verification
The bench builds the block with its default widths: a 4-bit exponent and a 3-bit fraction. With these widths every encoding is an integer multiple of 2^-9, and the largest sums stay below 2^18. The reference model can therefore form the exact sum as an integer and find the nearest even encoding by scanning all codes, without a floating-point datapath of its own.

At this size, the following are all reached by a few thousand random pairs plus a directed set:
- exponent gaps beyond the alignment width;
- ties;
- cancellation down to the denormal boundary;
- carry-out into overflow.

Random back-pressure on `m_ready` exercises stall and hold.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef struct packed {
    logic ovf;
    logic inx;
    logic inv;
  } mf_flags_t;
endpackage

// File: rtl/mf_unpack.sv
module mf_unpack #(
  parameter int EW = 4,
  parameter int FW = 3
) (
  input  logic [EW+FW:0] x,
  input  logic           flip,
  output logic           sgn,
  output logic [EW-1:0]  eeff,
  output logic [FW:0]    sig,
  output logic           is_inf,
  output logic           is_nan
);
  logic [EW-1:0] ef;
  logic [FW-1:0] fr;
  assign ef     = x[EW+FW-1:FW];
  assign fr     = x[FW-1:0];
  assign sgn    = x[EW+FW] ^ flip;
  // denormals share the scale of exponent field 1 and lack the hidden bit
  assign eeff   = (ef == '0) ? EW'(1) : ef;
  assign sig    = {ef != '0, fr};
  assign is_inf = (ef == '1) && (fr == '0);
  assign is_nan = (ef == '1) && (fr != '0);
endmodule

// File: rtl/mf_align_add.sv
module mf_align_add #(
  parameter int EW = 4,
  parameter int FW = 3,
  localparam int XW = FW + 4
) (
  input  logic          sa,
  input  logic [EW-1:0] ea,
  input  logic [FW:0]   siga,
  input  logic          sb,
  input  logic [EW-1:0] eb,
  input  logic [FW:0]   sigb,
  output logic          sum_sgn,
  output logic [EW-1:0] sum_exp,
  output logic [XW:0]   sum,
  output logic          eff_sub
);
  logic          a_big;
  logic [EW-1:0] e_hi, e_lo, d;
  logic [XW-1:0] hi_ext, lo_ext, lo_al;
  logic          stk;

  assign a_big   = {ea, siga} >= {eb, sigb};
  assign e_hi    = a_big ? ea : eb;
  assign e_lo    = a_big ? eb : ea;
  assign hi_ext  = {(a_big ? siga : sigb), 3'b000};
  assign lo_ext  = {(a_big ? sigb : siga), 3'b000};
  assign d       = e_hi - e_lo;
  assign sum_sgn = a_big ? sa : sb;
  assign sum_exp = e_hi;
  assign eff_sub = sa ^ sb;

  always_comb begin
    stk = 1'b0;
    for (int i = 0; i < XW; i++)
      if (i < int'(d)) stk = stk | lo_ext[i];
    lo_al    = lo_ext >> d;
    lo_al[0] = lo_al[0] | stk;
  end

  assign sum = eff_sub ? ({1'b0, hi_ext} - {1'b0, lo_al})
                       : ({1'b0, hi_ext} + {1'b0, lo_al});
endmodule

// File: rtl/mf_norm_round.sv
module mf_norm_round #(
  parameter int EW = 4,
  parameter int FW = 3,
  localparam int XW  = FW + 4,
  localparam int EXW = EW + 2,
  localparam int EMAX = (1 << EW) - 1
) (
  input  logic           sgn,
  input  logic [EW-1:0]  exp_in,
  input  logic [XW:0]    sum,
  input  logic           eff_sub,
  output logic [EW+FW:0] res,
  output logic           ovf,
  output logic           inx
);
  logic [XW-1:0]  n;
  logic [EXW-1:0] e, e2;
  logic [FW:0]    m, mf;
  logic [FW+1:0]  mr;
  logic           g, r, s, up, rsgn;
  int             lz, k;

  always_comb begin
    lz = XW;
    for (int i = 0; i < XW; i++)
      if (sum[i]) lz = XW - 1 - i;
    k = 0;
    if (sum[XW]) begin
      n = {sum[XW:2], |sum[1:0]};
      e = EXW'(exp_in) + EXW'(1);
    end else begin
      k = (lz < int'(exp_in) - 1) ? lz : int'(exp_in) - 1;
      n = sum[XW-1:0] << k;
      e = EXW'(exp_in) - EXW'(k);
    end
  end

  assign m  = n[XW-1:3];
  assign g  = n[2];
  assign r  = n[1];
  assign s  = n[0];
  assign up = g & (r | s | m[0]);
  assign mr = {1'b0, m} + (FW+2)'(up);

  always_comb begin
    if (mr[FW+1]) begin
      mf = mr[FW+1:1];
      e2 = e + EXW'(1);
    end else begin
      mf = mr[FW:0];
      e2 = e;
    end
  end

  assign ovf  = e2 >= EXW'(EMAX);
  assign inx  = g | r | s | ovf;
  assign rsgn = (mf == '0 && eff_sub) ? 1'b0 : sgn;

  always_comb begin
    if (ovf)
      res = {sgn, {EW{1'b1}}, {FW{1'b0}}};
    else
      res = {rsgn, (mf[FW] ? e2[EW-1:0] : {EW{1'b0}}), mf[FW-1:0]};
  end
endmodule

// File: rtl/mf_adder.sv
module mf_adder #(
  parameter int EW = 4,
  parameter int FW = 3,
  localparam int W  = EW + FW + 1,
  localparam int XW = FW + 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_a,
  input  logic [W-1:0] s_b,
  input  logic         s_sub,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_result,
  output logic         m_ovf,
  output logic         m_inx,
  output logic         m_inv
);
  import mf_pkg::*;

  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic          sa, sb, a_inf, b_inf, a_nan, b_nan, sum_sgn, eff_sub;
  logic [EW-1:0] ea, eb, sum_exp;
  logic [FW:0]   siga, sigb;
  logic [XW:0]   sum;
  logic [W-1:0]  fin_res, nxt_res;
  logic          fin_ovf, fin_inx;
  mf_flags_t     nxt_flg;

  mf_unpack #(.EW(EW), .FW(FW)) u_ua (
    .x(s_a), .flip(1'b0), .sgn(sa), .eeff(ea), .sig(siga),
    .is_inf(a_inf), .is_nan(a_nan));
  mf_unpack #(.EW(EW), .FW(FW)) u_ub (
    .x(s_b), .flip(s_sub), .sgn(sb), .eeff(eb), .sig(sigb),
    .is_inf(b_inf), .is_nan(b_nan));

  mf_align_add #(.EW(EW), .FW(FW)) u_add (
    .sa(sa), .ea(ea), .siga(siga), .sb(sb), .eb(eb), .sigb(sigb),
    .sum_sgn(sum_sgn), .sum_exp(sum_exp), .sum(sum), .eff_sub(eff_sub));

  mf_norm_round #(.EW(EW), .FW(FW)) u_nr (
    .sgn(sum_sgn), .exp_in(sum_exp), .sum(sum), .eff_sub(eff_sub),
    .res(fin_res), .ovf(fin_ovf), .inx(fin_inx));

  always_comb begin
    nxt_flg = '0;
    if (a_nan || b_nan) begin
      nxt_res = QNAN;
    end else if (a_inf && b_inf && (sa != sb)) begin
      nxt_res     = QNAN;
      nxt_flg.inv = 1'b1;
    end else if (a_inf) begin
      nxt_res = {sa, {EW{1'b1}}, {FW{1'b0}}};
    end else if (b_inf) begin
      nxt_res = {sb, {EW{1'b1}}, {FW{1'b0}}};
    end else begin
      nxt_res     = fin_res;
      nxt_flg.ovf = fin_ovf;
      nxt_flg.inx = fin_inx;
    end
  end

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_result <= '0;
      m_ovf    <= 1'b0;
      m_inx    <= 1'b0;
      m_inv    <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        m_result <= nxt_res;
        m_ovf    <= nxt_flg.ovf;
        m_inx    <= nxt_flg.inx;
        m_inv    <= nxt_flg.inv;
      end
    end
  end
endmodule

// File: rtl/mf_adder_chk.sv
module mf_adder_chk #(
  parameter int EW = 4,
  parameter int FW = 3,
  localparam int W = EW + FW + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         s_valid,
  input logic         s_ready,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_result,
  input logic         m_ovf,
  input logic         m_inx,
  input logic         m_inv
);
  logic res_nan;
  assign res_nan = (m_result[W-2:FW] == '1) && (m_result[FW-1:0] != '0);

  // R10: a stalled result holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_result) && $stable(m_ovf)
                            && $stable(m_inx) && $stable(m_inv));

  // R10: accepted input appears next cycle
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid);

  // R5: overflow yields infinity and inexact
  a_r5_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ovf |-> m_result[W-2:FW] == '1 && m_result[FW-1:0] == '0 && m_inx);

  // R7: invalid yields the canonical NaN
  a_r7_inv_nan: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_inv |-> res_nan && !m_ovf && !m_inx);

  // R6: NaN results carry no overflow or inexact
  a_r6_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && res_nan |-> !m_ovf && !m_inx);
endmodule

bind mf_adder mf_adder_chk #(.EW(EW), .FW(FW)) chk_i (.*);

// File: tb/mf_adder_tb_top.sv
module mf_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND      = 4000;
  localparam int NDIR       = 17;
  localparam int MAXCYC     = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, s_sub = 1'b0, m_ready = 1'b0;
  logic [7:0] s_a = '0, s_b = '0;
  logic       s_ready, m_valid, m_ovf, m_inx, m_inv;
  logic [7:0] m_result;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mf_adder dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_a(s_a), .s_b(s_b), .s_sub(s_sub), .m_valid(m_valid), .m_ready(m_ready),
    .m_result(m_result), .m_ovf(m_ovf), .m_inx(m_inx), .m_inv(m_inv));

  // magnitude of a code in units of 2^-9; code 0x78 treated as 256
  function automatic int mag(input int c);
    int e, f;
    e = (c >> 3) & 15;
    f = c & 7;
    if (e == 0) return f;
    return (8 + f) << (e - 1);
  endfunction

  function automatic int sval(input logic [7:0] x);
    return x[7] ? -mag(int'(x[6:0])) : mag(int'(x[6:0]));
  endfunction

  // returns {result, ovf, inx, inv}; tag names the requirement in play
  function automatic logic [10:0] model(input logic [7:0] a, input logic [7:0] b0,
                                        input logic sub, output string tag);
    logic [7:0] b, res;
    logic ovf, inx, inv, an, bn, ai, bi, sg, tie;
    int s, m, c, lo, hi;
    b   = {b0[7] ^ sub, b0[6:0]};
    an  = a[6:3] == 4'hF && a[2:0] != 0;
    bn  = b[6:3] == 4'hF && b[2:0] != 0;
    ai  = a[6:0] == 7'h78;
    bi  = b[6:0] == 7'h78;
    ovf = 0; inx = 0; inv = 0; tie = 0;
    if (an || bn) begin
      tag = "R6"; res = 8'h7C;
    end else if (ai && bi && a[7] != b[7]) begin
      tag = "R7"; res = 8'h7C; inv = 1;
    end else if (ai || bi) begin
      tag = "R9"; res = ai ? a : b;
    end else begin
      s = sval(a) + sval(b);
      m = (s < 0) ? -s : s;
      sg = (s < 0) ? 1'b1 : (s == 0 ? (a[7] & b[7]) : 1'b0);
      c = 0;
      for (int i = 0; i <= 120; i++) if (mag(i) <= m) c = i;
      if (mag(c) == m || c == 120) begin
        inx = (mag(c) != m);
      end else begin
        inx = 1;
        lo = mag(c); hi = mag(c + 1);
        if (2 * m > lo + hi) c = c + 1;
        else if (2 * m == lo + hi) begin
          tie = 1;
          if (c % 2 == 1) c = c + 1;
        end
      end
      if (c == 120) begin ovf = 1; inx = 1; end
      res = {sg, 7'(c)};
      if (ovf) tag = "R5";
      else if (s == 0) tag = "R8";
      else if (tie) tag = "R3";
      else if (res[6:3] == 0 || a[6:3] == 0 || b[6:3] == 0) tag = "R4";
      else if (inx) tag = "R2";
      else tag = "R1";
    end
    return {res, ovf, inx, inv};
  endfunction

  function automatic logic [16:0] dir_vec(input int i);
    case (i)
      0:  return {8'h38, 8'h38, 1'b0};  // R1
      1:  return {8'h38, 8'h30, 1'b1};  // R1
      2:  return {8'h38, 8'h01, 1'b0};  // R2
      3:  return {8'h38, 8'h18, 1'b0};  // R3 tie down
      4:  return {8'h39, 8'h18, 1'b0};  // R3 tie up
      5:  return {8'h08, 8'h01, 1'b1};  // R4
      6:  return {8'h04, 8'h04, 1'b0};  // R4
      7:  return {8'h77, 8'h77, 1'b0};  // R5
      8:  return {8'hF7, 8'h70, 1'b1};  // R5 negative
      9:  return {8'h79, 8'h38, 1'b0};  // R6
      10: return {8'h78, 8'h78, 1'b1};  // R7
      11: return {8'h38, 8'h38, 1'b1};  // R8
      12: return {8'h80, 8'h80, 1'b0};  // R8
      13: return {8'hB8, 8'h38, 1'b0};  // R8
      14: return {8'h78, 8'h38, 1'b0};  // R9
      15: return {8'h38, 8'h78, 1'b1};  // R9
      default: return {8'h77, 8'h08, 1'b0}; // R2
    endcase
  endfunction

  initial begin
    logic [10:0] expq[$];
    string       tagq[$];
    logic [10:0] exp_v, held;
    logic        stalled;
    string       tg;
    logic [16:0] v;
    int          sent, cyc;
    sent = 0; cyc = 0; stalled = 0; held = '0;

    repeat (3) @(negedge clk);
    checks++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      fails++;
      $display("FAIL R11 reset: m_valid=%b s_ready=%b expected 0 1", m_valid, s_ready);
    end
    rst_n = 1'b1;

    while ((sent < NDIR + NRAND || expq.size() > 0) && cyc < MAXCYC) begin
      @(negedge clk);
      cyc++;
      if (!(s_valid && !s_ready)) begin
        if (sent < NDIR + NRAND && ($urandom % 4 != 0)) begin
          v = (sent < NDIR) ? dir_vec(sent) : 17'($urandom);
          s_valid = 1'b1; s_a = v[16:9]; s_b = v[8:1]; s_sub = v[0];
        end else s_valid = 1'b0;
      end
      m_ready = ($urandom % 3 != 0);
      #1;
      if (stalled) begin
        checks++;
        if (!m_valid || {m_result, m_ovf, m_inx, m_inv} !== held) begin
          fails++;
          $display("FAIL R10 hold: got %b/%h expected 1/%h", m_valid,
                   {m_result, m_ovf, m_inx, m_inv}, held);
        end
      end
      checks++;
      if (s_ready !== (!m_valid || m_ready)) begin
        fails++;
        $display("FAIL R10 ready: got %b expected %b", s_ready, !m_valid || m_ready);
      end
      if (m_valid && m_ready) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected output: got %h expected none", m_result);
        end else begin
          exp_v = expq.pop_front();
          tg = tagq.pop_front();
          if ({m_result, m_ovf, m_inx, m_inv} !== exp_v) begin
            fails++;
            $display("FAIL %s res/ovf/inx/inv: got %h %b%b%b expected %h %b%b%b", tg,
                     m_result, m_ovf, m_inx, m_inv, exp_v[10:3], exp_v[2], exp_v[1], exp_v[0]);
          end
        end
      end
      stalled = m_valid && !m_ready;
      held = {m_result, m_ovf, m_inx, m_inv};
      if (s_valid && s_ready) begin
        exp_v = model(s_a, s_b, s_sub, tg);
        expq.push_back(exp_v);
        tagq.push_back(tg);
        sent++;
      end
    end
    if (cyc >= MAXCYC) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: %0d results pending expected 0", expq.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule